// File: doc/BRIEF.md
# Bipolar Line Error Counter

This block watches a bipolar line signal that arrives as two rails, one for positive pulses and one for negative pulses, sampled on the recovered line clock. In every clock cycle it decides whether the current sample is a line coding error, using one of two error definitions chosen by a mode input. It adds the errors to a 16-bit counter that a host reads one byte at a time.

In the first mode, called single-violation mode, the block counts every bipolar violation. It also counts every run of three or more zeros, once for each run. In the second mode, called pair mode, it counts only a bipolar violation that has the same polarity as the bipolar violation before it. Pair mode therefore lets substitution codes insert alternating violations without counting them.

A wrap-enable input selects how the counter behaves at its top value. When wrap-enable is 1 the counter wraps. When it is 0 the counter holds at its maximum and raises a sticky saturation flag. The host reads the low byte directly. A low-byte read strobe captures the high byte into a holding register, so the two bytes always come from the same count.

Top module: `line_err_counter`

## Requirements
- R1: The error count is 16 bits wide. `lo_byte_o` always shows count bits 7:0 and needs no strobe.
- R2: When `wrap_en_i` is 0, the count never goes beyond 65535 and stays at 65535 while further errors arrive.
- R3: `sat_o` rises in the cycle after an error brings the count to 65535 while `wrap_en_i` is 0. It then stays high until `sat_clr_i` is pulsed in a cycle with no new saturating error; a new saturating error takes priority over the clear.
- R4: When `wrap_en_i` is 1, the count wraps from 65535 to 0 and keeps counting. `sat_o` is not set in this case.
- R5: Rail encoding is {pos,neg}: 10 is a positive mark, 01 is a negative mark, 00 is a zero, and 11 is a mark with no polarity. A bipolar violation is a polarized mark whose polarity equals that of the last polarized mark since reset or since the last mode change. A 11 sample never updates that polarity. In single-violation mode (`mode_pair_i`=0) each bipolar violation adds one.
- R6: In single-violation mode, a run of three or more zero samples adds one when the mark that ends the run arrives. Runs of one or two zeros add nothing.
- R7: When that run-ending mark is itself a bipolar violation, the count rises by two in that cycle, subject to R2.
- R8: In pair mode (`mode_pair_i`=1), a bipolar violation adds one only if the previous bipolar violation had the same polarity. Zero runs add nothing in this mode.
- R9: A pulse on `rd_lo_i` copies count bits 15:8, as they stand in that cycle, into the register driven on `hi_byte_o`. The copy is visible from the next cycle.
- R10: A pulse on `cnt_clr_i` sets the count to 0 in the next cycle. Any error in that same cycle is discarded.
- R11: In a cycle where `mode_pair_i` differs from its value in the previous cycle, the sample is discarded, nothing is counted, and the polarity history and the zero-run tracker return to their reset state.
- R12: After reset the count, the high-byte hold register and `sat_o` are all 0, and no mark polarity has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_pair_i | input | 1 | 0 = single-violation mode, 1 = pair mode |
| pos_i | input | 1 | Positive-pulse rail |
| neg_i | input | 1 | Negative-pulse rail |
| wrap_en_i | input | 1 | 1 = wrap at the top value, 0 = saturate |
| cnt_clr_i | input | 1 | Synchronous count clear |
| sat_clr_i | input | 1 | Clears the sticky saturation flag |
| rd_lo_i | input | 1 | Low-byte read strobe; captures the high byte |
| lo_byte_o | output | 8 | Count bits 7:0 |
| hi_byte_o | output | 8 | Captured count bits 15:8 |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
Errors in the polarity register or the zero-run tracker stay hidden until the next mark arrives. At that point they show up on `lo_byte_o` as a step of the wrong size, one cycle after the mark. Because of this delay, the bench compares every cycle against its own model, using mark sequences whose outcome depends on history: alternating marks, runs that are too short, marks with no polarity, and a mode switch directly after a violation. A high byte that goes wrong only appears at the port after a read strobe, so reads are placed both past 255 and at saturation. A fault in the saturation path appears only after 65535 events, so the bench drives the counter all the way to its top value.

// File: rtl/line_err_pkg.sv
package line_err_pkg;

  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_POS  = 2'd1,
    POL_NEG  = 2'd2
  } pol_e;

  // Polarity carried by one rail sample; 00 and 11 carry none.
  function automatic pol_e rail_pol(input logic p, input logic n);
    if (p && !n)      return POL_POS;
    else if (n && !p) return POL_NEG;
    else              return POL_NONE;
  endfunction

  // A sample is a mark when either rail is high.
  function automatic logic rail_mark(input logic p, input logic n);
    return p | n;
  endfunction

  // Number of error events raised in one cycle.
  function automatic logic [1:0] event_sum(input logic a, input logic b,
                                           input logic c);
    return 2'({1'b0, a}) + 2'({1'b0, b}) + 2'({1'b0, c});
  endfunction

endpackage

// File: rtl/line_err_polarity.sv
module line_err_polarity
  import line_err_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic pos,
  input  logic neg,
  output logic mark,
  output logic bpv,
  output logic pair_viol
);

  pol_e last_mark_q;
  pol_e last_bpv_q;
  pol_e cur_pol;

  always_comb begin
    cur_pol   = rail_pol(pos, neg);
    mark      = rail_mark(pos, neg);
    bpv       = (cur_pol != POL_NONE) && (cur_pol == last_mark_q);
    pair_viol = bpv && (last_bpv_q == cur_pol);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      last_mark_q <= POL_NONE;
      last_bpv_q  <= POL_NONE;
    end else begin
      if (cur_pol != POL_NONE) last_mark_q <= cur_pol;
      if (bpv)                 last_bpv_q  <= cur_pol;
    end
  end

endmodule

// File: rtl/line_err_zero_run.sv
module line_err_zero_run #(
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic mark,
  output logic run_end
);

  localparam int ZW = $clog2(RUN_LEN + 1);
  localparam logic [ZW-1:0] ZTOP = ZW'(RUN_LEN);

  logic [ZW-1:0] zeros_q;

  // The run is counted once, on the mark that closes it.
  assign run_end = mark && (zeros_q == ZTOP);

  always_ff @(posedge clk) begin
    if (!rst_n || flush)     zeros_q <= '0;
    else if (mark)           zeros_q <= '0;
    else if (zeros_q != ZTOP) zeros_q <= zeros_q + 1'b1;
  end

endmodule

// File: rtl/line_err_accum.sv
module line_err_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wrap_en,
  input  logic [1:0]       inc,
  input  logic             sat_clr,
  output logic [CNT_W-1:0] count,
  output logic             sat_flag
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] count_q;
  logic             sat_q;
  logic [CNT_W:0]   sum_w;
  logic             sat_hit;

  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W:0] s,
                                                input logic wrap);
    if (wrap)                   return s[CNT_W-1:0];
    else if (s > {1'b0, CMAX})  return CMAX;
    else                        return s[CNT_W-1:0];
  endfunction

  always_comb begin
    sum_w   = {1'b0, count_q} + {{(CNT_W-1){1'b0}}, inc};
    sat_hit = !clr && !wrap_en && (inc != 2'd0) && (sum_w >= {1'b0, CMAX});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      sat_q   <= 1'b0;
    end else begin
      count_q <= clr ? '0 : next_cnt(sum_w, wrap_en);
      if (sat_hit)      sat_q <= 1'b1;
      else if (sat_clr) sat_q <= 1'b0;
    end
  end

  assign count    = count_q;
  assign sat_flag = sat_q;

endmodule

// File: rtl/line_err_readout.sv
module line_err_readout #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_lo,
  input  logic [CNT_W-1:0]   count,
  output logic [CNT_W/2-1:0] lo_byte,
  output logic [CNT_W/2-1:0] hi_byte
);

  localparam int HALF = CNT_W / 2;

  logic [HALF-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     hold_q <= '0;
    else if (rd_lo) hold_q <= count[CNT_W-1:HALF];
  end

  assign lo_byte = count[HALF-1:0];
  assign hi_byte = hold_q;

endmodule

// File: rtl/line_err_counter.sv
module line_err_counter
  import line_err_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RUN_LEN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_pair_i,
  input  logic               pos_i,
  input  logic               neg_i,
  input  logic               wrap_en_i,
  input  logic               cnt_clr_i,
  input  logic               sat_clr_i,
  input  logic               rd_lo_i,
  output logic [CNT_W/2-1:0] lo_byte_o,
  output logic [CNT_W/2-1:0] hi_byte_o,
  output logic               sat_o
);

  logic             mode_q;
  logic             mode_sw;
  logic             mark;
  logic             bpv;
  logic             pair_viol;
  logic             run_end;
  logic             ev_bpv;
  logic             ev_run;
  logic             ev_pair;
  logic [1:0]       inc;
  logic [CNT_W-1:0] count;

  // The mode is captured during reset, so the first cycle is not a switch.
  always_ff @(posedge clk) mode_q <= mode_pair_i;

  always_comb begin
    mode_sw = rst_n && (mode_pair_i != mode_q);
    ev_bpv  = !mode_sw && !mode_pair_i && bpv;
    ev_run  = !mode_sw && !mode_pair_i && run_end;
    ev_pair = !mode_sw &&  mode_pair_i && pair_viol;
    inc     = event_sum(ev_bpv, ev_run, ev_pair);
  end

  line_err_polarity u_pol (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (mode_sw),
    .pos       (pos_i),
    .neg       (neg_i),
    .mark      (mark),
    .bpv       (bpv),
    .pair_viol (pair_viol)
  );

  line_err_zero_run #(.RUN_LEN(RUN_LEN)) u_zrun (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (mode_sw),
    .mark    (mark),
    .run_end (run_end)
  );

  line_err_accum #(.CNT_W(CNT_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr_i),
    .wrap_en  (wrap_en_i),
    .inc      (inc),
    .sat_clr  (sat_clr_i),
    .count    (count),
    .sat_flag (sat_o)
  );

  line_err_readout #(.CNT_W(CNT_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_lo   (rd_lo_i),
    .count   (count),
    .lo_byte (lo_byte_o),
    .hi_byte (hi_byte_o)
  );

endmodule

// File: rtl/line_err_counter_chk.sv
module line_err_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_sw,
  input logic             cnt_clr,
  input logic             wrap_en,
  input logic             sat_clr,
  input logic             sat,
  input logic [1:0]       inc,
  input logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  // R10: a clear pulse empties the counter
  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (count == '0));

  // R2: saturating counter stays at its top value
  assert_sat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_en && !cnt_clr && count == CMAX) |=> (count == CMAX));

  // R3: saturation flag is sticky without a clear pulse
  assert_sat_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !sat_clr) |=> sat);

  // R4: wrapping counter moves by the event count modulo its width
  assert_wrap_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_en && !cnt_clr) |=> (CNT_W'(count - $past(count)) == CNT_W'($past(inc))));

  // R11: a mode switch cycle counts nothing
  assert_switch_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sw && !cnt_clr) |=> $stable(count));

endmodule

bind line_err_counter line_err_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode_sw (mode_sw),
  .cnt_clr (cnt_clr_i),
  .wrap_en (wrap_en_i),
  .sat_clr (sat_clr_i),
  .sat     (sat_o),
  .inc     (inc),
  .count   (count)
);

// File: tb/sim_line_err_counter.sv
`timescale 1ns/1ps
module sim_line_err_counter;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, mode, pos, neg, wrap, cclr, sclr, rd;
  logic [7:0] lo, hi;
  logic sat;

  line_err_counter u0 (
    .clk(clk), .rst_n(rst_n), .mode_pair_i(mode), .pos_i(pos), .neg_i(neg),
    .wrap_en_i(wrap), .cnt_clr_i(cclr), .sat_clr_i(sclr), .rd_lo_i(rd),
    .lo_byte_o(lo), .hi_byte_o(hi), .sat_o(sat)
  );

  int checks = 0, errors = 0;
  // model: polarity 0 none, 1 positive, -1 negative
  int m_cnt, m_hold, m_lp, m_lv, m_z, m_pm;
  bit m_sat;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step();
    int inc = 0, p = 0;
    bit mk, v;
    if (int'(mode) != m_pm) begin
      m_lp = 0; m_lv = 0; m_z = 0;
    end else begin
      mk = pos | neg;
      p  = (pos && !neg) ? 1 : ((neg && !pos) ? -1 : 0);
      v  = (p != 0) && (p == m_lp);
      if (!mode) begin
        if (v) inc++;
        if (mk && m_z >= 3) inc++;
      end else if (v && m_lv == p) inc++;
      if (v) m_lv = p;
      if (p != 0) m_lp = p;
      m_z = mk ? 0 : ((m_z < 3) ? m_z + 1 : 3);
    end
    m_pm = int'(mode);
    if (rd) m_hold = m_cnt / 256;
    if (!cclr && !wrap && inc > 0 && m_cnt + inc >= 65535) m_sat = 1'b1;
    else if (sclr) m_sat = 1'b0;
    if (cclr) m_cnt = 0;
    else if (wrap) m_cnt = (m_cnt + inc) % 65536;
    else m_cnt = (m_cnt + inc > 65535) ? 65535 : m_cnt + inc;
  endtask

  task automatic step(input logic p, input logic n);
    pos = p; neg = n;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R1/R5/R6/R8 low byte vs model", int'(lo), m_cnt % 256);
    chk("R9 high byte vs model", int'(hi), m_hold);
    chk("R3 sat flag vs model", int'(sat), int'(m_sat));
    rd = 0; cclr = 0; sclr = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; mode = 0; pos = 0; neg = 0; wrap = 1; cclr = 0; sclr = 0; rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_cnt = 0; m_hold = 0; m_sat = 0; m_lp = 0; m_lv = 0; m_z = 0; m_pm = 0;
    chk("R12 reset low", int'(lo), 0);
    chk("R12 reset high", int'(hi), 0);
    chk("R12 reset sat", int'(sat), 0);

    // single-violation mode
    step(1,0); step(0,1); step(1,0); step(1,0); step(0,1); step(0,1);
    chk("R5 two violations", int'(lo), 2);
    repeat (4) step(0,0);
    step(1,0);
    chk("R6 long zero run", int'(lo), 3);
    step(0,0); step(0,0); step(1,0);
    chk("R6 short run ignored, violation counted", int'(lo), 4);
    repeat (3) step(0,0);
    step(1,0);
    chk("R7 run end plus violation", int'(lo), 6);
    step(1,1); step(1,0);
    chk("R5 unpolarized mark keeps history", int'(lo), 7);

    // pair mode
    mode = 1;
    step(1,0);
    chk("R11 switch cycle discarded", int'(lo), 7);
    step(1,0);
    chk("R11 history cleared", int'(lo), 7);
    step(0,1); step(0,1); step(1,0); step(1,0); step(0,1); step(1,0); step(1,0);
    chk("R8 same polarity pair", int'(lo), 8);
    repeat (5) step(0,0);
    step(0,1);
    chk("R8 zero run ignored", int'(lo), 8);

    // clear beats event
    mode = 0;
    step(0,0);
    step(1,0);
    cclr = 1;
    step(1,0);
    chk("R10 clear with event", int'(lo), 0);

    // high byte capture
    repeat (300) step(1,0);
    rd = 1;
    step(0,0);
    chk("R9 captured high byte", int'(hi), 1);
    chk("R1 low byte", int'(lo), 44);

    // saturation
    wrap = 0; cclr = 1;
    step(0,0);
    repeat (65540) step(1,0);
    rd = 1;
    step(0,0);
    chk("R2 saturated low", int'(lo), 255);
    chk("R2 saturated high", int'(hi), 255);
    chk("R3 flag set", int'(sat), 1);
    sclr = 1;
    step(1,0);
    chk("R3 set beats clear", int'(sat), 1);
    sclr = 1;
    step(0,0);
    chk("R3 flag cleared", int'(sat), 0);

    // wrap
    wrap = 1;
    step(1,0);
    chk("R4 wrapped to zero", int'(lo), 0);
    rd = 1;
    step(1,0);
    chk("R4 counting after wrap", int'(lo), 1);
    chk("R4 high byte after wrap", int'(hi), 0);
    chk("R4 no sat in wrap mode", int'(sat), 0);

    summary();
    $finish;
  end

endmodule